// File: doc/BRIEF.md
# Compare Flag Generator

This block evaluates a compare between two operands and produces the four condition flags that later conditional decisions test: negative, zero, carry and signed overflow. It runs in one of two modes. In subtract mode it forms A minus B. In add mode it forms A plus B, which is a compare against the negated second operand. The arithmetic result is used only inside the block to derive the flags and is never driven out.

The flags are held in a small register. A new set is written only when an operation is strobed valid together with a flag-update request. After each write, a one-cycle pulse signals that fresh flags are present. On subtraction, carry uses the not-borrow convention: C=1 means that no borrow occurred, so C alone tells whether A is unsigned higher than or equal to B.

Top module: `cmpflag_top`

## Requirements
- R1: op_mode selects the operation: 0 forms A - B and 1 forms A + B (32-bit wrap-around). After an update, flags_n equals bit 31 of that result.
- R2: After an update, flags_z is 1 exactly when all 32 bits of the result are zero.
- R3: In subtract mode (op_mode=0), flags_c is 1 exactly when A >= B as unsigned numbers. Equal operands give Z=1 and C=1, and 0 - 1 gives C=0 and N=1.
- R4: In add mode (op_mode=1), flags_c is the carry out of the unsigned 32-bit sum.
- R5: flags_v is 1 exactly when the two's-complement result overflows in either mode. For example, 0x80000000 - 1 gives V=1.
- R6: The flags change only on a rising edge where op_valid and op_upd are both 1, and they hold their value at every other edge. A valid operation without an update request has no effect on them.
- R7: flags_valid is 1 for the single cycle that follows an update edge, and 0 at all other times.
- R8: Synchronous active-high reset clears all four flags and flags_valid on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_upd | input | 1 | Flag-update request accompanying the operation |
| op_mode | input | 1 | 0 = subtract (A - B), 1 = add (A + B) |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| flags_n | output | 1 | Registered negative flag |
| flags_z | output | 1 | Registered zero flag |
| flags_c | output | 1 | Registered carry / not-borrow flag |
| flags_v | output | 1 | Registered signed-overflow flag |
| flags_valid | output | 1 | One-cycle pulse after each flag update |

## Verification
The assertions relate the registered flags to the operands present at the preceding update edge. They therefore assume that op_a, op_b and op_mode are stable around each rising edge and that rst is not raised in the same cycle as an update they rely on. The bench drives all inputs on the falling edge, so every value is settled well before the edge that samples it. The bench covers the named corner operands in both modes, valid strobes with and without the update request, and idle gaps. It then runs a long stretch of random operands, some of them biased toward sign-boundary values. Reset is raised once mid-run, when the flags are nonzero.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

    localparam int unsigned CMP_DATA_W = 32;

    typedef enum logic {
        CMP_SUB = 1'b0,
        CMP_ADD = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cmp_flags_t;

    localparam cmp_flags_t CMP_FLAGS_CLR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    // Signed overflow: both addends share a sign that the sum does not.
    function automatic logic cmp_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
        return (a_msb == b_msb) && (r_msb != a_msb);
    endfunction

endpackage

// File: rtl/cmpflag_operand.sv
module cmpflag_operand
    import cmpflag_pkg::*;
#(
    parameter int unsigned DATA_W = CMP_DATA_W
) (
    input  logic [DATA_W-1:0] b_in,
    input  cmp_mode_e         mode,
    output logic [DATA_W-1:0] b_eff,
    output logic              carry_in
);
    // Subtraction becomes A + ~B + 1, so carry-out acts as not-borrow.
    always_comb begin
        if (mode == CMP_SUB) begin
            b_eff    = ~b_in;
            carry_in = 1'b1;
        end else begin
            b_eff    = b_in;
            carry_in = 1'b0;
        end
    end
endmodule

// File: rtl/cmpflag_alu.sv
module cmpflag_alu
    import cmpflag_pkg::*;
#(
    parameter int unsigned DATA_W = CMP_DATA_W
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_eff,
    input  logic              carry_in,
    output cmp_flags_t        flags
);
    localparam int unsigned SUM_W = DATA_W + 1;
    localparam int unsigned MSB   = DATA_W - 1;

    logic [SUM_W-1:0]  sum_full;
    logic [DATA_W-1:0] result;

    always_comb begin
        sum_full = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};
        result   = sum_full[DATA_W-1:0];
        flags.n  = result[MSB];
        flags.z  = (result == '0);
        flags.c  = sum_full[DATA_W];
        flags.v  = cmp_ovf(a_in[MSB], b_eff[MSB], result[MSB]);
    end
endmodule

// File: rtl/cmpflag_reg.sv
module cmpflag_reg
    import cmpflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cmp_flags_t flags_d,
    output cmp_flags_t flags_q,
    output logic       pulse_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= CMP_FLAGS_CLR;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= load;
            if (load) begin
                flags_q <= flags_d;
            end
        end
    end

    // R6: no load means the stored flags stay put
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(flags_q));

    // R7: pulse follows a load by exactly one cycle
    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> pulse_q);

    p_nopulse_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> !pulse_q);

    // R8: reset clears everything
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (flags_q == CMP_FLAGS_CLR) && !pulse_q);
endmodule

// File: rtl/cmpflag_top.sv
module cmpflag_top
    import cmpflag_pkg::*;
#(
    parameter int unsigned DATA_W = CMP_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_upd,
    input  logic              op_mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              flags_n,
    output logic              flags_z,
    output logic              flags_c,
    output logic              flags_v,
    output logic              flags_valid
);
    localparam int unsigned MSB = DATA_W - 1;

    cmp_mode_e         mode;
    logic [DATA_W-1:0] b_eff;
    logic              carry_in;
    cmp_flags_t        flags_comb;
    cmp_flags_t        flags_q;
    logic              load;

    assign mode = cmp_mode_e'(op_mode);
    assign load = op_valid && op_upd;

    cmpflag_operand #(.DATA_W(DATA_W)) u_operand (
        .b_in     (op_b),
        .mode     (mode),
        .b_eff    (b_eff),
        .carry_in (carry_in)
    );

    cmpflag_alu #(.DATA_W(DATA_W)) u_alu (
        .a_in     (op_a),
        .b_eff    (b_eff),
        .carry_in (carry_in),
        .flags    (flags_comb)
    );

    cmpflag_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .flags_d (flags_comb),
        .flags_q (flags_q),
        .pulse_q (flags_valid)
    );

    assign flags_n = flags_q.n;
    assign flags_z = flags_q.z;
    assign flags_c = flags_q.c;
    assign flags_v = flags_q.v;

    // Reference values for the assertions, formed straight from the ports
    logic [DATA_W-1:0] chk_diff;
    logic [DATA_W-1:0] chk_sum;
    logic              chk_sub_ovf;
    logic              chk_add_ovf;
    assign chk_diff    = op_a - op_b;
    assign chk_sum     = op_a + op_b;
    assign chk_sub_ovf = (op_a[MSB] != op_b[MSB]) && (chk_diff[MSB] != op_a[MSB]);
    assign chk_add_ovf = (op_a[MSB] == op_b[MSB]) && (chk_sum[MSB] != op_a[MSB]);

    p_sign_sub_r1: assert property (@(posedge clk) disable iff (rst)
        (load && !op_mode) |=> flags_n == $past(chk_diff[MSB]));

    p_zero_sub_r2: assert property (@(posedge clk) disable iff (rst)
        (load && !op_mode) |=> flags_z == $past(op_a == op_b));

    p_unsigned_c_r3: assert property (@(posedge clk) disable iff (rst)
        (load && !op_mode) |=> flags_c == $past(op_a >= op_b));

    p_carry_add_r4: assert property (@(posedge clk) disable iff (rst)
        (load && op_mode) |=> flags_c == $past(chk_sum < op_a));

    p_no_overflow_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !op_mode) |=> flags_v == $past(chk_sub_ovf));

    p_no_overflow_add_r5: assert property (@(posedge clk) disable iff (rst)
        (load && op_mode) |=> flags_v == $past(chk_add_ovf));
endmodule

// File: tb/cmpflag_top_test.sv
module cmpflag_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_upd = 1'b0;
    logic        op_mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        flags_n, flags_z, flags_c, flags_v, flags_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cmpflag_top uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_upd(op_upd),
        .op_mode(op_mode), .op_a(op_a), .op_b(op_b),
        .flags_n(flags_n), .flags_z(flags_z), .flags_c(flags_c),
        .flags_v(flags_v), .flags_valid(flags_valid)
    );

    // Behavioural reference: returns {n,z,c,v}
    function automatic logic [3:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                             input logic add);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint sres;
        longint ures;
        logic [31:0] r;
        logic n, z, c, v;
        if (add) begin
            ures = ua + ub;
            sres = sa + sb;
            c = (ures >= 64'sd4294967296);
        end else begin
            ures = ua - ub;
            sres = sa - sb;
            c = (ua >= ub);
        end
        r = ures[31:0];
        n = r[31];
        z = (r == 32'd0);
        v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
        return {n, z, c, v};
    endfunction

    // Model state, advanced each rising edge
    logic [3:0] m_flags = 4'b0;
    logic       m_valid = 1'b0;
    logic       m_mode  = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_flags <= 4'b0;
            m_valid <= 1'b0;
        end else begin
            m_valid <= op_valid && op_upd;
            if (op_valid && op_upd) begin
                m_flags <= ref_flags(op_a, op_b, op_mode);
                m_mode  <= op_mode;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every falling edge against the model
    always @(negedge clk) begin
        if (!done) begin
            check(flags_n == m_flags[3], "R1 negative flag", 32'(flags_n), 32'(m_flags[3]));
            check(flags_z == m_flags[2], "R2 zero flag", 32'(flags_z), 32'(m_flags[2]));
            check(flags_c == m_flags[1], m_mode ? "R4 add carry" : "R3 not-borrow carry",
                  32'(flags_c), 32'(m_flags[1]));
            check(flags_v == m_flags[0], "R5 overflow flag", 32'(flags_v), 32'(m_flags[0]));
            check(flags_valid == m_valid, "R7 flags_valid pulse", 32'(flags_valid), 32'(m_valid));
        end
    end

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic add,
                         input logic v, input logic u);
        @(negedge clk);
        op_a = a; op_b = b; op_mode = add; op_valid = v; op_upd = u;
    endtask

    task automatic expect_flags(input logic [3:0] exp, input string req);
        @(negedge clk);
        #1;
        check({flags_n, flags_z, flags_c, flags_v} == exp, req,
              32'({flags_n, flags_z, flags_c, flags_v}), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check({flags_n, flags_z, flags_c, flags_v, flags_valid} == 5'b0, "R8 reset state",
              32'({flags_n, flags_z, flags_c, flags_v, flags_valid}), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3: equal operands -> Z=1, C=1
        drive(32'd77, 32'd77, 1'b0, 1'b1, 1'b1);
        drive(32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        #1 check({flags_n, flags_z, flags_c, flags_v} == 4'b0110, "R3 equal operands",
                 32'({flags_n, flags_z, flags_c, flags_v}), 32'h6);
        // R5: 0x80000000 - 1 -> V=1, C=1
        drive(32'h8000_0000, 32'd1, 1'b0, 1'b1, 1'b1);
        expect_flags(4'b0011, "R5 min minus one");
        // R3 / R1: 0 - 1 -> N=1, C=0
        drive(32'd0, 32'd1, 1'b0, 1'b1, 1'b1);
        expect_flags(4'b1000, "R3 zero minus one");
        // R6: valid without update request leaves flags alone
        drive(32'd5, 32'd5, 1'b0, 1'b1, 1'b0);
        expect_flags(4'b1000, "R6 valid without update");
        // R6: update request without valid also ignored
        drive(32'd5, 32'd5, 1'b0, 1'b0, 1'b1);
        expect_flags(4'b1000, "R6 update without valid");
        // R4: add mode carry out and zero: 0xFFFFFFFF + 1
        drive(32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1, 1'b1);
        expect_flags(4'b0110, "R4 add wraps to zero");
        // R5 / R1: add overflow 0x7FFFFFFF + 1
        drive(32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, 1'b1);
        expect_flags(4'b1001, "R5 add positive overflow");
        // R2: nonzero result clears Z
        drive(32'd3, 32'd9, 1'b1, 1'b1, 1'b1);
        expect_flags(4'b0000, "R2 nonzero sum");

        // Random traffic, some operands pinned near sign boundaries
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 4) == 0) ra = {ra[31], 31'h7FFF_FFFF ^ {31{ra[0]}}};
            if (($urandom % 5) == 0) rb = ra;
            drive(ra, rb, 1'($urandom), 1'(($urandom % 4) != 0), 1'(($urandom % 3) != 0));
            if (i == 1500) begin
                // R8: mid-run reset with flags likely nonzero
                drive(32'h0, 32'h1, 1'b0, 1'b1, 1'b1);
                @(negedge clk);
                rst = 1'b1; op_valid = 1'b0;
                @(negedge clk);
                #1 check({flags_n, flags_z, flags_c, flags_v, flags_valid} == 5'b0,
                         "R8 mid-run reset",
                         32'({flags_n, flags_z, flags_c, flags_v, flags_valid}), 32'd0);
                rst = 1'b0;
            end
        end
        drive(32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule